// File: doc/BRIEF.md
# Searchable Store Buffer Queue

This block holds stores that have left the pipeline but have not yet been written to the memory hierarchy. Each slot keeps one address together with one data word. Stores come in through a valid/ready input stream and leave strictly oldest-first through a valid/ready output stream. The downstream consumer can see the head entry before it accepts it.

Loads can probe the buffer at any time through a purely combinational lookup port. The port takes an address. It reports whether any stored entry has that address, and if so it returns the data of the youngest such entry, so a load always observes the latest store still waiting. The lookup runs in the same cycle as any enqueue and dequeue and sees the contents as they stood at the start of that cycle. Stores are never merged, and matching is on the whole address only.

Back-pressure works as follows. The producer may drop `in_valid` at any time. A store is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is low only when every slot is occupied and the head is not leaving in the same cycle. The consumer takes the head on an edge where `out_valid` and `out_ready` are both high. While the consumer holds `out_ready` low, the head address and head data do not change.

Top module: `store_queue`

## Requirements
- R1: A store presented with `in_valid` high while `in_ready` is high is captured with both its address and its data, and it appears unchanged when it later reaches the head.
- R2: With all DEPTH slots occupied and `out_ready` low, `in_ready` is low, and the offered store is not captured.
- R3: When one or more occupied slots hold `lk_addr`, `lk_hit` is high and `lk_data` equals the data of the most recently accepted of them.
- R4: `out_valid` is high exactly when at least one slot is occupied. While `out_ready` is low, `out_addr` and `out_data` keep their values.
- R5: Entries leave in the order they were accepted, one per cycle in which `out_valid` and `out_ready` are both high.
- R6: When no occupied slot holds `lk_addr`, `lk_hit` is low and `lk_data` is all zeros.
- R7: The lookup reflects the occupancy at the start of the cycle. An entry leaving in the current cycle still matches, and a store accepted in the current cycle does not match until the next cycle.
- R8: When all slots are full and `out_ready` is high, `in_ready` is high, and a store and a removal happen in the same cycle, leaving the buffer full.
- R9: After reset the buffer is empty: `out_valid` low, `in_ready` high, `lk_hit` low.
- R10: A slot that has been drained never produces a hit, even though its old contents remain in storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Producer offers a store |
| in_ready | output | 1 | Buffer can take the offered store this cycle |
| in_addr | input | AW | Address of the offered store |
| in_data | input | DW | Data of the offered store |
| out_valid | output | 1 | Head entry present |
| out_ready | input | 1 | Consumer removes the head this cycle |
| out_addr | output | AW | Address of the oldest entry |
| out_data | output | DW | Data of the oldest entry |
| lk_addr | input | AW | Address probed by a load |
| lk_hit | output | 1 | Some occupied slot holds `lk_addr` |
| lk_data | output | DW | Data of the youngest matching entry, zero on a miss |

## Verification
The assertions assume reset is applied from time zero and that every input has a known level at each rising edge. They do not assume that the producer keeps `in_valid` high until the store is accepted, and they do not assume that the consumer keeps `out_ready` up. The bench changes every input only at the falling clock edge. It drops and raises `in_valid` and `out_ready` freely, including while the buffer is full. It draws addresses from a pool of four values so that repeated stores to one address, probes of the head while it leaves, and probes of drained slots occur often.

// File: rtl/stq_pkg.sv
package stq_pkg;
  // Per-cycle occupancy operation, encoded as {push, pop}.
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_POP  = 2'b01,
    OP_PUSH = 2'b10,
    OP_BOTH = 2'b11
  } stq_op_e;
endpackage

// File: rtl/stq_ctrl.sv
module stq_ctrl #(
  parameter int DEPTH = 4,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  output logic [PW-1:0] head,
  output logic [PW-1:0] tail,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  import stq_pkg::*;

  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  stq_op_e op;
  assign op = stq_op_e'({push, pop});

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (push) tail <= bump(tail);
      if (pop)  head <= bump(head);
      case (op)
        OP_PUSH: count <= count + 1'b1;
        OP_POP:  count <= count - 1'b1;
        default: ;
      endcase
    end
  end

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);

  // R2: occupancy never exceeds the number of slots
  p_count_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R5: a push alone into a non-empty buffer leaves the head in place
  p_head_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pop) |=> $stable(head));
endmodule

// File: rtl/stq_search.sv
module stq_search #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic [AW-1:0] slot_addr [DEPTH],
  input  logic [DW-1:0] slot_data [DEPTH],
  input  logic [PW-1:0] head,
  input  logic [CW-1:0] count,
  input  logic [AW-1:0] key,
  output logic          hit,
  output logic [DW-1:0] data
);
  // Match vector and data laid out by age: index 0 is the oldest entry.
  logic [DEPTH-1:0] age_match;
  logic [DW-1:0]    age_data [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_age
    logic [PW:0]   sum;
    logic [PW:0]   wrapped;
    logic [PW-1:0] slot;
    assign sum     = {1'b0, head} + (PW + 1)'(g);
    assign wrapped = (sum >= (PW + 1)'(DEPTH)) ? sum - (PW + 1)'(DEPTH) : sum;
    assign slot    = wrapped[PW-1:0];
    assign age_match[g] = (CW'(g) < count) && (slot_addr[slot] == key);
    assign age_data[g]  = slot_data[slot];
  end

  // Later (younger) matches override earlier ones.
  always_comb begin
    hit  = 1'b0;
    data = '0;
    for (int a = 0; a < DEPTH; a++) begin
      if (age_match[a]) begin
        hit  = 1'b1;
        data = age_data[a];
      end
    end
  end
endmodule

// File: rtl/store_queue.sv
module store_queue #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_addr,
  output logic [DW-1:0] out_data,
  input  logic [AW-1:0] lk_addr,
  output logic          lk_hit,
  output logic [DW-1:0] lk_data
);
  logic [AW-1:0] mem_addr [DEPTH];
  logic [DW-1:0] mem_data [DEPTH];
  logic [PW-1:0] head, tail;
  logic [CW-1:0] count;
  logic          full, empty, push, pop;

  assign out_valid = !empty;
  assign in_ready  = !full || out_ready;
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;

  stq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .pop   (pop),
    .head  (head),
    .tail  (tail),
    .count (count),
    .full  (full),
    .empty (empty)
  );

  always_ff @(posedge clk) begin
    if (push) begin
      mem_addr[tail] <= in_addr;
      mem_data[tail] <= in_data;
    end
  end

  assign out_addr = mem_addr[head];
  assign out_data = mem_data[head];

  stq_search #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_search (
    .slot_addr (mem_addr),
    .slot_data (mem_data),
    .head      (head),
    .count     (count),
    .key       (lk_addr),
    .hit       (lk_hit),
    .data      (lk_data)
  );

  // R1: a store accepted into an empty buffer is the head next cycle
  p_fill_head_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && in_valid) |=> (out_valid && out_addr == $past(in_addr)
                                  && out_data == $past(in_data)));

  // R2: a refused store leaves the occupancy unchanged
  p_refuse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (full && in_valid && !out_ready) |=> $stable(count));

  // R4: the head holds while the consumer stalls
  p_head_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)
                                   && $stable(out_data)));

  // R8: a store and a removal together keep a full buffer full
  p_full_both_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (full && in_valid && out_ready) |=> full);

  // R10: an empty buffer never reports a hit
  p_empty_miss_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid) |-> !lk_hit);
endmodule

// File: tb/test_store_queue.sv
`timescale 1ns/100ps
module test_store_queue;
  localparam int DEPTH = 4;
  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [AW-1:0] in_addr = '0;
  logic [DW-1:0] in_data = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [AW-1:0] out_addr;
  logic [DW-1:0] out_data;
  logic [AW-1:0] lk_addr = '0;
  logic          lk_hit;
  logic [DW-1:0] lk_data;

  always #2.5 clk = ~clk;

  store_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) i_store_queue (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr), .out_data(out_data),
    .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_data(lk_data)
  );

  typedef struct { logic [AW-1:0] a; logic [DW-1:0] d; } item_t;
  item_t sb[$];

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus; checks lookup and in_ready against the
  // scoreboard contents, then records any accepted store.
  task automatic step(input bit push, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input bit take, input logic [AW-1:0] probe, input string tag);
    bit            exp_hit;
    logic [DW-1:0] exp_dat;
    bit            exp_rdy;
    @(negedge clk);
    in_valid  = push;
    in_addr   = a;
    in_data   = d;
    out_ready = take;
    lk_addr   = probe;
    #0.5;
    exp_hit = 0;
    exp_dat = '0;
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].a == probe) begin
        exp_hit = 1;
        exp_dat = sb[i].d;
        break;
      end
    end
    exp_rdy = (sb.size() < DEPTH) || (take && sb.size() > 0);
    chk(lk_hit == exp_hit, (tag != "") ? tag : (exp_hit ? "R3 hit" : "R6 hit"), 64'(lk_hit), 64'(exp_hit));
    chk(lk_data == exp_dat, (tag != "") ? tag : (exp_hit ? "R3 data" : "R6 data"), 64'(lk_data), 64'(exp_dat));
    chk(in_ready == exp_rdy, (sb.size() == DEPTH) ? "R2 R8 ready" : "R1 ready", 64'(in_ready), 64'(exp_rdy));
    #1.0;
    if (push && exp_rdy) sb.push_back('{a: a, d: d});
  endtask

  // Monitor: compares the head against the scoreboard and pops on removal.
  initial begin
    forever begin
      @(negedge clk);
      #1.0;
      if (rst_n) begin
        chk(out_valid == (sb.size() != 0), "R4 valid", 64'(out_valid), 64'(sb.size() != 0));
        if (out_valid && sb.size() != 0) begin
          chk(out_addr == sb[0].a, "R1 R5 addr", 64'(out_addr), 64'(sb[0].a));
          chk(out_data == sb[0].d, "R1 R5 data", 64'(out_data), 64'(sb[0].d));
          if (out_ready) void'(sb.pop_front());
        end
      end
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #0.5;
    // R9: state after reset
    chk(out_valid == 1'b0, "R9 out_valid", 64'(out_valid), 64'd0);
    chk(in_ready == 1'b1, "R9 in_ready", 64'(in_ready), 64'd1);
    chk(lk_hit == 1'b0, "R9 lk_hit", 64'(lk_hit), 64'd0);

    // R7: a store accepted this cycle is not yet visible
    step(1, 32'h10, 32'hA1, 0, 32'h10, "R7 same-cycle push");
    step(1, 32'h20, 32'hB2, 0, 32'h10, "");
    step(1, 32'h10, 32'hC3, 0, 32'h10, "R3 youngest of two");
    step(0, 32'h0,  32'h0,  0, 32'h10, "R3 youngest of two");
    step(0, 32'h0,  32'h0,  0, 32'h30, "R6 absent address");
    step(1, 32'h30, 32'hD4, 0, 32'h20, "");
    // R2: full, no removal: offered store refused
    step(1, 32'h40, 32'hE5, 0, 32'h40, "R2 refused not stored");
    step(0, 32'h0,  32'h0,  0, 32'h40, "R2 refused not stored");
    // R8: full with store and removal together; R7: leaving head still matches
    step(1, 32'h50, 32'hF6, 1, 32'h10, "R7 R8 head leaving");
    step(1, 32'h60, 32'h17, 1, 32'h20, "R7 R8 head leaving");
    step(0, 32'h0,  32'h0,  0, 32'h60, "R8 both accepted");
    // R4: stall with head held, then drain
    step(0, 32'h0, 32'h0, 0, 32'h10, "");
    step(0, 32'h0, 32'h0, 1, 32'h10, "");
    step(0, 32'h0, 32'h0, 1, 32'h30, "");
    step(0, 32'h0, 32'h0, 1, 32'h50, "");
    step(0, 32'h0, 32'h0, 1, 32'h60, "");
    // R10: drained slots still hold old contents but never hit
    step(0, 32'h0, 32'h0, 0, 32'h10, "R10 drained slot");
    step(0, 32'h0, 32'h0, 0, 32'h60, "R10 drained slot");
    step(1, 32'h70, 32'h28, 0, 32'h30, "R10 drained slot");
    step(0, 32'h0, 32'h0, 1, 32'h20, "R10 drained slot");

    // Mixed traffic over a small address pool.
    for (int k = 0; k < 600; k++) begin
      logic [AW-1:0] pa, pr;
      pa = 32'h100 + 32'(($urandom % 4) * 8);
      pr = 32'h100 + 32'(($urandom % 4) * 8);
      step(($urandom % 3) != 0, pa, $urandom, ($urandom % 2) == 1, pr, "");
    end
    for (int k = 0; k < DEPTH + 2; k++) step(0, 32'h0, 32'h0, 1, 32'h108, "");
    step(0, 32'h0, 32'h0, 0, 32'h108, "R10 after drain");

    @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule